// File: doc/BRIEF.md
# Power-Save Clock Control Unit

This block holds a 16-bit control word that decides how fast the core runs and what appears on two clock-output pins. When software sets the power-save enable, the core clock enable pulses only once every 2^F input cycles, where F is a three-bit divide select. Otherwise it pulses on every cycle. The divide ratio only changes on a divided-clock boundary, so the core never sees a short period.

A hardware interrupt that is taken, from an external pin or from an on-chip peripheral, clears the power-save enable by itself. A software interrupt or an exception leaves it alone. Returning from the handler does not set it again, so software must write it back if it wants power saving again. Each of the two clock pins can follow the fast input-rate waveform or the divided internal waveform, and each can be forced low on its own.

Top module: `psclk_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0000h, `core_ce` is high on every cycle, and both clock pins are low.
- R2: A write stores bit 15 (power-save enable), bits 11..8 (pin controls) and bits 2..0 (divide select F), and `rd_data` shows the new value from the cycle after the write. Bits 14..12 and 7..3 always read as 0.
- R3: While bit 15 is 1, `core_ce` is high for one cycle in every 2^F cycles (F=000 gives every cycle, F=111 gives one in 128). While bit 15 is 0, `core_ce` is high on every cycle once the divider has reached a boundary.
- R4: If `irq_take` is high with `irq_kind` 0 (external) or 1 (peripheral), bit 15 reads 0 from the next cycle. All other bits are unchanged.
- R5: If `irq_take` is high with `irq_kind` 2 (software) or 3 (exception), bit 15 is unchanged.
- R6: If a hardware interrupt is taken in the same cycle as a write, bit 15 becomes 0 and the other written bits are stored.
- R7: Once bit 15 has been cleared, it stays 0 until software writes a 1 to it. There is no automatic restore.
- R8: The divide ratio changes only in a cycle where `core_ce` was high. After a ratio change, every gap between `core_ce` pulses equals either the old ratio or the new ratio.
- R9: Bit 11 picks the source for `clkout_b`. When it is 1, the pin toggles every input cycle, giving rising edges 2 cycles apart. When it is 0, the pin follows the divided waveform, with rising edges 2*ratio cycles apart.
- R10: Bit 10 set to 1 holds `clkout_b` low from the next cycle, overriding bit 11.
- R11: Bits 9 and 8 control `clkout_a` in the same way that bits 11 and 10 control `clkout_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| irq_take | input | 1 | Strobe: an interrupt or exception is being taken |
| irq_kind | input | 2 | Kind of the event: 0 external, 1 peripheral, 2 software, 3 exception |
| rd_data | output | 16 | Current control word |
| core_ce | output | 1 | Core clock enable, divided in power-save mode |
| clkout_a | output | 1 | Clock output pin A |
| clkout_b | output | 1 | Clock output pin B |

## Verification
On every cycle, the assertions check the following: reserved bits read zero, a taken hardware interrupt clears the enable, software interrupts and exceptions leave it alone, a cleared enable stays cleared without a write, the force-low controls act on the pins, and the divide ratio moves only after a `core_ce` pulse. The bench's scenarios cover the rest. Directed runs measure the actual gaps between `core_ce` pulses and between pin rising edges for several ratios and sources. They also show what happens across a ratio change and when an interrupt collides with a write. A seeded random phase compares `rd_data` on every cycle against a register model.

// File: rtl/psclk_pkg.sv
package psclk_pkg;
  localparam int REG_W  = 16;
  localparam int SEL_W  = 3;
  localparam int NPIN   = 2;
  localparam int CNT_W  = (1 << SEL_W) - 1;

  // bit positions of the control word
  localparam int BIT_PS     = 15;
  localparam int BIT_B_FAST = 11;
  localparam int BIT_B_LOW  = 10;
  localparam int BIT_A_FAST = 9;
  localparam int BIT_A_LOW  = 8;

  localparam logic [REG_W-1:0] WR_MASK = 16'h8F07;

  typedef enum logic [1:0] {
    IRQ_EXT    = 2'd0,
    IRQ_PERIPH = 2'd1,
    IRQ_SOFT   = 2'd2,
    IRQ_EXC    = 2'd3
  } irq_kind_e;
endpackage

// File: rtl/psclk_regs.sv
module psclk_regs
  import psclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_take,
  input  logic [1:0]       irq_kind,
  output logic [REG_W-1:0] ctrl_q
);
  logic hw_clear;
  irq_kind_e kind;

  assign kind     = irq_kind_e'(irq_kind);
  assign hw_clear = irq_take && (kind == IRQ_EXT || kind == IRQ_PERIPH);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_en) ctrl_q <= wr_data & WR_MASK;
      // interrupt clear takes priority over a same-cycle write
      if (hw_clear) ctrl_q[BIT_PS] <= 1'b0;
    end
  end
endmodule

// File: rtl/psclk_divider.sv
module psclk_divider
  import psclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ps_on,
  input  logic [SEL_W-1:0] div_sel,
  output logic             core_ce,
  output logic             div_wave,
  output logic [SEL_W-1:0] eff_sel
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic [SEL_W-1:0] target;
  logic             tick;

  // terminal count = 2^eff_sel - 1 as a thermometer mask
  always_comb begin
    term = '0;
    for (int i = 0; i < CNT_W; i++) term[i] = (SEL_W'(i) < eff_sel);
  end

  assign tick    = (cnt == term);
  assign core_ce = tick;
  assign target  = ps_on ? div_sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      eff_sel  <= '0;
      div_wave <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      eff_sel  <= target;   // ratio moves only on a boundary
      div_wave <= ~div_wave;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psclk_pinout.sv
module psclk_pinout
  import psclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            div_wave,
  input  logic [NPIN-1:0] use_fast,
  input  logic [NPIN-1:0] force_low,
  output logic [NPIN-1:0] pin_q
);
  logic fast_wave;

  always_ff @(posedge clk) begin
    if (rst) fast_wave <= 1'b0;
    else     fast_wave <= ~fast_wave;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst || force_low[g]) pin_q[g] <= 1'b0;
      else if (use_fast[g])    pin_q[g] <= fast_wave;
      else                     pin_q[g] <= div_wave;
    end
  end
endmodule

// File: rtl/psclk_ctrl.sv
module psclk_ctrl
  import psclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        irq_take,
  input  logic [1:0]  irq_kind,
  output logic [15:0] rd_data,
  output logic        core_ce,
  output logic        clkout_a,
  output logic        clkout_b
);
  logic [REG_W-1:0] ctrl_q;
  logic             div_wave;
  logic [SEL_W-1:0] eff_sel;
  logic [NPIN-1:0]  pins;

  psclk_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_take(irq_take), .irq_kind(irq_kind), .ctrl_q(ctrl_q)
  );

  psclk_divider u_div (
    .clk(clk), .rst(rst), .ps_on(ctrl_q[BIT_PS]),
    .div_sel(ctrl_q[SEL_W-1:0]), .core_ce(core_ce),
    .div_wave(div_wave), .eff_sel(eff_sel)
  );

  psclk_pinout u_pins (
    .clk(clk), .rst(rst), .div_wave(div_wave),
    .use_fast({ctrl_q[BIT_B_FAST], ctrl_q[BIT_A_FAST]}),
    .force_low({ctrl_q[BIT_B_LOW], ctrl_q[BIT_A_LOW]}),
    .pin_q(pins)
  );

  assign rd_data  = ctrl_q;
  assign clkout_a = pins[0];
  assign clkout_b = pins[1];
endmodule

// File: rtl/psclk_ctrl_chk.sv
module psclk_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        irq_take,
  input logic [1:0]  irq_kind,
  input logic [15:0] rd_data,
  input logic        core_ce,
  input logic        clkout_a,
  input logic        clkout_b,
  input logic [2:0]  eff_sel
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 16'h70F8) == 16'h0000);

  assert_hw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_kind[1] == 1'b0) |=> !rd_data[15]);

  assert_sw_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_kind[1] && !wr_en) |=> rd_data[15] == $past(rd_data[15]));

  assert_no_restore_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[15] && !wr_en) |=> !rd_data[15]);

  assert_ratio_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(eff_sel) |-> $past(core_ce));

  assert_force_low_b_R10: assert property (@(posedge clk) disable iff (rst)
    rd_data[10] |=> !clkout_b);

  assert_force_low_a_R11: assert property (@(posedge clk) disable iff (rst)
    rd_data[8] |=> !clkout_a);
endmodule

bind psclk_ctrl psclk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq_take(irq_take),
  .irq_kind(irq_kind), .rd_data(rd_data), .core_ce(core_ce),
  .clkout_a(clkout_a), .clkout_b(clkout_b), .eff_sel(eff_sel)
);

// File: tb/psclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module psclk_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_take = 1'b0;
  logic [1:0]  irq_kind = '0;
  logic [15:0] rd_data;
  logic        core_ce, clkout_a, clkout_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] model = '0;

  always #2.5 clk = ~clk;

  psclk_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_take(irq_take), .irq_kind(irq_kind), .rd_data(rd_data),
    .core_ce(core_ce), .clkout_a(clkout_a), .clkout_b(clkout_b)
  );

  function automatic logic [15:0] next_word(logic [15:0] cur, logic we,
      logic [15:0] d, logic take, logic [1:0] kind);
    logic [15:0] r;
    r = we ? (d & 16'h8F07) : cur;
    if (take && kind < 2) r[15] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply one cycle of inputs, then compare the control word
  task automatic step(input logic we, input logic [15:0] d,
                      input logic take, input logic [1:0] kind, input string tag);
    wr_en = we; wr_data = d; irq_take = take; irq_kind = kind;
    model = next_word(model, we, d, take, kind);
    @(negedge clk);
    chk(rd_data == model, tag, rd_data, model);
    wr_en = 1'b0; irq_take = 1'b0;
  endtask

  task automatic ce_gap(output int g);
    int c = 0;
    while (!core_ce && c < 2000) begin @(negedge clk); c++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!core_ce && g < 2000);
  endtask

  task automatic pin_gap(input bit use_b, output int g);
    logic prev;
    int c = 0;
    prev = use_b ? clkout_b : clkout_a;
    forever begin
      @(negedge clk); c++;
      if ((use_b ? clkout_b : clkout_a) && !prev) break;
      prev = use_b ? clkout_b : clkout_a;
      if (c > 2000) break;
    end
    g = 0;
    prev = 1'b1;
    do begin
      @(negedge clk); g++;
      if ((use_b ? clkout_b : clkout_a) && !prev) break;
      prev = use_b ? clkout_b : clkout_a;
    end while (g < 2000);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int g;
    int seed;
    bit all_low;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 16'h0000, "R1 reset word", rd_data, 0);
    chk(core_ce == 1'b1, "R1 reset core_ce", core_ce, 1);
    chk(!clkout_a && !clkout_b, "R1 reset pins", {clkout_a, clkout_b}, 0);

    // R2 write with reserved bits set
    step(1, 16'hFFFF, 0, 0, "R2 reserved bits masked");
    step(1, 16'h0000, 0, 0, "R2 clear");

    // R3 divide ratios
    for (int f = 0; f < 8; f += 3) begin
      step(1, 16'h8000 | 16'(f), 0, 0, "R3 set ratio");
      ce_gap(g); ce_gap(g);
      chk(g == (1 << f), "R3 ce gap in power-save", g, 1 << f);
    end

    // R5 software and exception keep power-save on
    step(0, 0, 1, 2'd2, "R5 software irq keeps enable");
    step(0, 0, 1, 2'd3, "R5 exception keeps enable");
    chk(rd_data[15] == 1'b1, "R5 enable still set", rd_data[15], 1);

    // R4 hardware clears, others kept
    step(1, 16'h8A03, 0, 0, "R4 setup");
    step(0, 0, 1, 2'd1, "R4 peripheral irq clears");
    chk(rd_data == 16'h0A03, "R4 other bits kept", rd_data, 16'h0A03);
    // R7 stays off, core runs full rate
    repeat (20) step(0, 0, 1, 2'd2, "R7 no restore");
    ce_gap(g); ce_gap(g);
    chk(g == 1, "R7 full rate after clear", g, 1);
    step(1, 16'h8003, 0, 0, "R7 rewrite sets");
    step(1, 16'h8002, 1, 2'd0, "R6 clear beats write");
    chk(rd_data == 16'h0002, "R6 collision word", rd_data, 16'h0002);

    // R8 ratio change: 4 to 32
    step(1, 16'h8002, 0, 0, "R8 setup");
    ce_gap(g); ce_gap(g);
    step(1, 16'h8005, 0, 0, "R8 change");
    for (int k = 0; k < 3; k++) begin
      ce_gap(g);
      chk(g == 4 || g == 32, "R8 gap old or new", g, 32);
    end
    chk(g == 32, "R8 settles to new ratio", g, 32);

    // R9 pin B sources
    step(1, 16'h8802, 0, 0, "R9 fast source");
    pin_gap(1'b1, g);
    chk(g == 2, "R9 B fast period", g, 2);
    step(1, 16'h8002, 0, 0, "R9 divided source");
    repeat (10) @(negedge clk);
    pin_gap(1'b1, g);
    chk(g == 8, "R9 B divided period", g, 8);
    // R10 force low
    step(1, 16'h8C02, 0, 0, "R10 force low");
    all_low = 1'b1;
    repeat (40) begin @(negedge clk); if (clkout_b) all_low = 1'b0; end
    chk(all_low, "R10 B held low", clkout_b, 0);
    // R11 pin A
    step(1, 16'h0200, 0, 0, "R11 A fast");
    repeat (3) @(negedge clk);
    pin_gap(1'b0, g);
    chk(g == 2, "R11 A fast period", g, 2);
    step(1, 16'h8003, 0, 0, "R11 A divided");
    repeat (20) @(negedge clk);
    pin_gap(1'b0, g);
    chk(g == 16, "R11 A divided period", g, 16);
    step(1, 16'h0300, 0, 0, "R11 A force low");
    all_low = 1'b1;
    repeat (20) begin @(negedge clk); if (clkout_a) all_low = 1'b0; end
    chk(all_low, "R11 A held low", clkout_a, 0);

    // random mix, R2 R4 R5 R6 model
    for (int n = 0; n < 400; n++) begin
      logic we, tk;
      we = ($urandom % 4) == 0;
      tk = ($urandom % 5) == 0;
      step(we, 16'($urandom), tk, 2'($urandom), "R2 R4 R5 R6 random model");
    end

    finish_run();
  end
endmodule